// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the hazard control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) for a machine with 16-bit instruction words and eight registers. It holds the fetch PC and a control copy of the instruction word in each of the four inter-stage latches. From those words it works out when a load is followed straight away by an instruction that reads the loaded register. In that case it freezes fetch for one cycle and sends an empty slot into execute. The execute stage reports a wrongly predicted branch through a flag and a correct-path address. The controller then empties the two younger latches and points fetch at the correct path.

The datapath around it supplies the fetched word and the predictor's next-PC guess. The datapath reads back the hold, bubble and flush controls and the fetch PC. A halt instruction that reaches the writeback stage stops the whole pipeline until the next reset. The empty slot is the word 0x0000, which encodes an add of register 0 into register 0.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: A synchronous active-low reset sets fetch_pc to 0, loads 0x0000 into all four latch words and clears halted. Reset takes effect from any state, a halted state included.
- R2: With no hazard, each clock edge loads pred_pc into fetch_pc and imem_rdata into the fetch/decode word. Each older latch takes the word of the latch before it.
- R3: ifid_hold is asserted in the same cycle under these conditions: the decode/execute word is a load (opcode bits [15:13] = 101) whose destination field [12:10] is nonzero, and the fetch/decode word reads that register. add (000) reads fields [9:7] and [2:0]. addi (001) and load read [9:7]. bne (110) reads [12:10] and [9:7]. Other opcodes read nothing.
- R4: In a cycle with ifid_hold, idex_bubble is asserted. At the edge, fetch_pc and the fetch/decode word keep their values, the decode/execute word becomes 0x0000 and the load moves on to execute/memory.
- R5: A load-use stall lasts one cycle. On the next edge the dependent instruction enters decode/execute.
- R6: No stall arises when the load's destination is register 0, or when the fetch/decode instruction does not read that register. No stall arises when the decode/execute word is not a load.
- R7: When ex_mispredict is high, pipe_flush and idex_bubble are asserted. At the edge both the fetch/decode and decode/execute words become 0x0000, the branch moves into execute/memory and fetch_pc loads ex_fix_pc.
- R8: When a flush and a load-use stall fall in the same cycle, the flush wins: ifid_hold stays low.
- R9: When the memory/writeback word is a halt (opcode 111), halted is set at the next edge and stays set. While halted, fetch_pc and all latch words hold, and ifid_hold and pipe_flush stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_rdata | input | 16 | Instruction word fetched at fetch_pc |
| pred_pc | input | PC_W | Predicted next fetch address |
| ex_mispredict | input | 1 | Branch in execute resolved against the prediction |
| ex_fix_pc | input | PC_W | Correct-path address for a misprediction |
| fetch_pc | output | PC_W | Current fetch address |
| ifid_hold | output | 1 | Load-use stall: hold PC and fetch/decode latch |
| idex_bubble | output | 1 | Decode/execute latch takes an empty slot this edge |
| pipe_flush | output | 1 | Squash the two younger latches this edge |
| ifid_instr | output | 16 | Fetch/decode latch word |
| idex_instr | output | 16 | Decode/execute latch word |
| exmem_instr | output | 16 | Execute/memory latch word |
| memwb_instr | output | 16 | Memory/writeback latch word |
| halted | output | 1 | Pipeline stopped by a halt in writeback |

## Verification
ifid_hold, idex_bubble and pipe_flush are combinational and are due in the same cycle as the inputs and latch words that cause them. The bench checks them 1 ns after it drives a cycle's inputs. Every latch word, fetch_pc and halted change on the edge that closes that cycle. For each driven cycle the bench queues the state expected after that one edge, and a monitor compares it 2 ns after the edge. halted is the one result that trails its cause by a full cycle: it rises on the edge after the halt enters memory/writeback. The script places the frozen-pipeline checks one cycle after that.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard controller.
// Assumes a 16-bit word: opcode [15:13], fields A [12:10], B [9:7], C [2:0].
package hz_pkg;
    localparam int INSTR_W = 16;
    localparam int REG_IDX_W = 3;
    localparam int OP_W = 3;

    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [REG_IDX_W-1:0] ridx_t;
    typedef logic [OP_W-1:0] opc_t;

    localparam opc_t OPC_ADD  = 3'b000;
    localparam opc_t OPC_ADDI = 3'b001;
    localparam opc_t OPC_LW   = 3'b101;
    localparam opc_t OPC_BNE  = 3'b110;
    localparam opc_t OPC_HALT = 3'b111;

    localparam instr_t NOP_WORD = '0;
endpackage

// File: rtl/hz_stage_reg.sv
// One pipeline latch of the control path.
// Loads RST_VAL on reset or kill, else loads d when adv is high, else holds.
// Assumes kill is already qualified by the caller (e.g. not while halted).
module hz_stage_reg #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         kill,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // latch update: reset, squash, advance, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (kill) begin
            q <= RST_VAL;
        end else if (adv) begin
            q <= d;
        end
    end
endmodule

// File: rtl/hz_loaduse.sv
// Load-use detector.
// Flags a hazard when the decode/execute slot is a load with a nonzero
// destination and the fetch/decode slot reads that register.
// Assumes register 0 is constant zero and so never carries a dependence.
module hz_loaduse
    import hz_pkg::*;
(
    input  opc_t  ex_op,
    input  ridx_t ex_dst,
    input  opc_t  dc_op,
    input  ridx_t dc_fa,
    input  ridx_t dc_fb,
    input  ridx_t dc_fc,
    output logic  hazard
);
    localparam int N_SRC = 3;

    ridx_t          src_idx [N_SRC];
    logic [N_SRC-1:0] src_use;
    logic [N_SRC-1:0] src_hit;
    logic           producer_ok;

    // which fields the younger instruction reads, by opcode
    always_comb begin
        src_idx[0] = dc_fa;
        src_idx[1] = dc_fb;
        src_idx[2] = dc_fc;
        src_use    = '0;
        unique case (dc_op)
            OPC_ADD:  src_use = 3'b110;
            OPC_ADDI: src_use = 3'b010;
            OPC_LW:   src_use = 3'b010;
            OPC_BNE:  src_use = 3'b011;
            default:  src_use = 3'b000;
        endcase
    end

    // older slot is a real load into a real register
    always_comb begin
        producer_ok = (ex_op == OPC_LW) && (ex_dst != '0);
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_src
            // compare one source field against the load destination
            always_comb begin
                src_hit[gi] = src_use[gi] && (src_idx[gi] == ex_dst);
            end
        end
    endgenerate

    // combine per-field matches
    always_comb begin
        hazard = producer_ok && (|src_hit);
    end
endmodule

// File: rtl/hz_fetch_pc.sv
// Fetch address register.
// Priority: reset, freeze (halted), redirect, hold (stall), predicted path.
// Assumes redirect and hold are never both set by the caller.
module hz_fetch_pc #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            freeze,
    input  logic            redirect,
    input  logic            hold,
    input  logic [PC_W-1:0] fix_pc,
    input  logic [PC_W-1:0] pred_pc,
    output logic [PC_W-1:0] pc
);
    logic [PC_W-1:0] pc_nxt;

    // choose the next fetch address
    always_comb begin
        if (freeze || hold) begin
            pc_nxt = pc;
        end else if (redirect) begin
            pc_nxt = fix_pc;
        end else begin
            pc_nxt = pred_pc;
        end
    end

    // PC register with synchronous reset to address 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            pc <= pc_nxt;
        end
    end
endmodule

// File: rtl/hz_pipe_ctrl.sv
// Pipeline hazard controller (top).
// Owns the fetch PC and a control copy of each latch word. It inserts a
// one-cycle load-use bubble and squashes the two younger slots on a branch
// mispredict reported by execute. A halt in writeback freezes everything.
// Assumes ex_mispredict refers to the instruction now in decode/execute.
module hz_pipe_ctrl
    import hz_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     imem_rdata,
    input  logic [PC_W-1:0] pred_pc,
    input  logic            ex_mispredict,
    input  logic [PC_W-1:0] ex_fix_pc,
    output logic [PC_W-1:0] fetch_pc,
    output logic            ifid_hold,
    output logic            idex_bubble,
    output logic            pipe_flush,
    output logic [15:0]     ifid_instr,
    output logic [15:0]     idex_instr,
    output logic [15:0]     exmem_instr,
    output logic [15:0]     memwb_instr,
    output logic            halted
);
    localparam int N_STG  = 4;
    localparam int N_TAIL = N_STG - 2;

    instr_t stg [N_STG];
    logic   lu_hazard;
    logic   run;

    assign run = !halted;

    // hazard detection on the two youngest latches
    hz_loaduse u_lu (
        .ex_op  (stg[1][15:13]),
        .ex_dst (stg[1][12:10]),
        .dc_op  (stg[0][15:13]),
        .dc_fa  (stg[0][12:10]),
        .dc_fb  (stg[0][9:7]),
        .dc_fc  (stg[0][2:0]),
        .hazard (lu_hazard)
    );

    // control outputs: flush beats stall, both silent while halted
    always_comb begin
        pipe_flush  = run && ex_mispredict;
        ifid_hold   = run && lu_hazard && !ex_mispredict;
        idex_bubble = ifid_hold || pipe_flush;
    end

    hz_fetch_pc #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (halted),
        .redirect (pipe_flush),
        .hold     (ifid_hold),
        .fix_pc   (ex_fix_pc),
        .pred_pc  (pred_pc),
        .pc       (fetch_pc)
    );

    hz_stage_reg #(.W(INSTR_W), .RST_VAL(NOP_WORD)) u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run && !ifid_hold),
        .kill  (pipe_flush),
        .d     (imem_rdata),
        .q     (stg[0])
    );

    hz_stage_reg #(.W(INSTR_W), .RST_VAL(NOP_WORD)) u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .kill  (idex_bubble),
        .d     (stg[0]),
        .q     (stg[1])
    );

    genvar gk;
    generate
        for (gk = 0; gk < N_TAIL; gk++) begin : g_tail
            hz_stage_reg #(.W(INSTR_W), .RST_VAL(NOP_WORD)) u_stg (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (run),
                .kill  (1'b0),
                .d     (stg[gk+1]),
                .q     (stg[gk+2])
            );
        end
    endgenerate

    // sticky halt once a halt word sits in the writeback-bound latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (stg[3][15:13] == OPC_HALT) begin
            halted <= 1'b1;
        end
    end

    assign ifid_instr  = stg[0];
    assign idex_instr  = stg[1];
    assign exmem_instr = stg[2];
    assign memwb_instr = stg[3];
endmodule

// File: rtl/hz_pipe_ctrl_chk.sv
// Property checker for hz_pipe_ctrl, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module hz_pipe_ctrl_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] ex_fix_pc,
    input logic [PC_W-1:0] fetch_pc,
    input logic            ifid_hold,
    input logic            idex_bubble,
    input logic            pipe_flush,
    input logic [15:0]     ifid_instr,
    input logic [15:0]     idex_instr,
    input logic [2:0]      wb_op,
    input logic            halted
);
    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold |-> idex_instr[15:13] == 3'b101); // R3
    AST_STALL_FREEZES_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold |=> $stable(fetch_pc) && $stable(ifid_instr)); // R4
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold |=> idex_instr == 16'h0000); // R4
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold |=> !ifid_hold); // R5
    AST_FLUSH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> ifid_instr == 16'h0000 && idex_instr == 16'h0000); // R7
    AST_FLUSH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |=> fetch_pc == $past(ex_fix_pc)); // R7
    AST_FLUSH_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |-> idex_bubble); // R7
    AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |-> !ifid_hold); // R8
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_op == 3'b111) |=> halted); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(fetch_pc) && $stable(ifid_instr)); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !ifid_hold && !pipe_flush); // R9
endmodule

bind hz_pipe_ctrl hz_pipe_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_fix_pc   (ex_fix_pc),
    .fetch_pc    (fetch_pc),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .pipe_flush  (pipe_flush),
    .ifid_instr  (ifid_instr),
    .idex_instr  (idex_instr),
    .wb_op       (memwb_instr[15:13]),
    .halted      (halted)
);

// File: tb/test_hz_pipe_ctrl.sv
// Scoreboard bench: the driver queues the state due after each edge,
// and the monitor pops and compares it just after that edge.
module test_hz_pipe_ctrl;
    localparam int CLK_NS = 10;
    localparam int PC_W = 16;
    localparam int WD_CYC = 200000;

    localparam logic [15:0] LW1   = 16'ha406; // lw  A=1 B=0
    localparam logic [15:0] LW0   = 16'ha080; // lw  A=0 B=1
    localparam logic [15:0] ADD   = 16'h0881; // add A=2 B=1 C=1
    localparam logic [15:0] ADDC  = 16'h0801; // add A=2 B=0 C=1
    localparam logic [15:0] ADDI  = 16'h3039; // addi A=4 B=0
    localparam logic [15:0] BNE11 = 16'hc4fd; // bne A=1 B=1
    localparam logic [15:0] BNE00 = 16'hc001; // bne A=0 B=0
    localparam logic [15:0] HALT  = 16'he071;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic [15:0]     w0, w1, w2, w3;
        logic            hl;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     imem_rdata = '0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            ex_mispredict = 1'b0;
    logic [PC_W-1:0] ex_fix_pc = '0;
    logic [PC_W-1:0] fetch_pc;
    logic            ifid_hold, idex_bubble, pipe_flush, halted;
    logic [15:0]     ifid_instr, idex_instr, exmem_instr, memwb_instr;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb [$];

    hz_pipe_ctrl #(.PC_W(PC_W)) i_hz_pipe_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .imem_rdata    (imem_rdata),
        .pred_pc       (pred_pc),
        .ex_mispredict (ex_mispredict),
        .ex_fix_pc     (ex_fix_pc),
        .fetch_pc      (fetch_pc),
        .ifid_hold     (ifid_hold),
        .idex_bubble   (idex_bubble),
        .pipe_flush    (pipe_flush),
        .ifid_instr    (ifid_instr),
        .idex_instr    (idex_instr),
        .exmem_instr   (exmem_instr),
        .memwb_instr   (memwb_instr),
        .halted        (halted)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input exp_t e);
        chk(e.tag, "fetch_pc",    32'(fetch_pc),    32'(e.pc));
        chk(e.tag, "ifid_instr",  32'(ifid_instr),  32'(e.w0));
        chk(e.tag, "idex_instr",  32'(idex_instr),  32'(e.w1));
        chk(e.tag, "exmem_instr", 32'(exmem_instr), 32'(e.w2));
        chk(e.tag, "memwb_instr", 32'(memwb_instr), 32'(e.w3));
        chk(e.tag, "halted",      32'(halted),      32'(e.hl));
    endtask

    // driver: one cycle of stimulus, same-cycle control checks, queued state
    task automatic cyc(input logic [15:0] im, input int pr, input logic mp,
                       input int fx, input logic e_hold, input logic e_flush,
                       input int pc, input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] w2, input logic [15:0] w3,
                       input logic hl, input string tag);
        exp_t e;
        @(negedge clk);
        imem_rdata    = im;
        pred_pc       = PC_W'(pr);
        ex_mispredict = mp;
        ex_fix_pc     = PC_W'(fx);
        #1;
        chk(tag, "ifid_hold",   32'(ifid_hold),   32'(e_hold));
        chk(tag, "pipe_flush",  32'(pipe_flush),  32'(e_flush));
        chk(tag, "idex_bubble", 32'(idex_bubble), 32'(e_hold | e_flush));
        e.pc = PC_W'(pc); e.w0 = w0; e.w1 = w1; e.w2 = w2; e.w3 = w3;
        e.hl = hl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset();
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; imem_rdata = '0; pred_pc = '0;
        ex_mispredict = 1'b0; ex_fix_pc = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e.pc = '0; e.w0 = '0; e.w1 = '0; e.w2 = '0; e.w3 = '0; e.hl = 1'b0;
        e.tag = "R1";
        check_state(e);
    endtask

    // monitor: compare queued state just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) check_state(sb.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // im      pred mp fx hold flush pc  ifid   idex   exmem  memwb  hl
        cyc(LW1,   1, 0, 0, 0, 0,  1, LW1,   16'h0, 16'h0, 16'h0, 0, "R2");
        cyc(ADD,   2, 0, 0, 0, 0,  2, ADD,   LW1,   16'h0, 16'h0, 0, "R2");
        cyc(BNE11, 0, 0, 0, 1, 0,  2, ADD,   16'h0, LW1,   16'h0, 0, "R3/R4");
        cyc(BNE11, 0, 0, 0, 0, 0,  0, BNE11, ADD,   16'h0, LW1,   0, "R5");
        cyc(LW1,   1, 0, 0, 0, 0,  1, LW1,   BNE11, ADD,   16'h0, 0, "R6");
        cyc(ADD,   2, 1, 3, 0, 1,  3, 16'h0, 16'h0, BNE11, ADD,   0, "R7");
        cyc(BNE00, 4, 0, 0, 0, 0,  4, BNE00, 16'h0, 16'h0, BNE11, 0, "R2");
        cyc(LW1,   5, 0, 0, 0, 0,  5, LW1,   BNE00, 16'h0, 16'h0, 0, "R2");
        cyc(ADD,   6, 0, 0, 0, 0,  6, ADD,   LW1,   BNE00, 16'h0, 0, "R2");
        cyc(ADDI,  7, 1, 9, 0, 1,  9, 16'h0, 16'h0, LW1,   BNE00, 0, "R8");
        cyc(LW1,  10, 0, 0, 0, 0, 10, LW1,   16'h0, 16'h0, LW1,   0, "R2");
        cyc(ADDI, 11, 0, 0, 0, 0, 11, ADDI,  LW1,   16'h0, 16'h0, 0, "R2");
        cyc(BNE11,12, 0, 0, 0, 0, 12, BNE11, ADDI,  LW1,   16'h0, 0, "R6");
        cyc(LW1,  13, 0, 0, 0, 0, 13, LW1,   BNE11, ADDI,  LW1,   0, "R2");
        cyc(ADD,  14, 0, 0, 0, 0, 14, ADD,   LW1,   BNE11, ADDI,  0, "R2");
        cyc(BNE11,15, 0, 0, 1, 0, 14, ADD,   16'h0, LW1,   BNE11, 0, "R3");
        cyc(LW0,  15, 0, 0, 0, 0, 15, LW0,   ADD,   16'h0, LW1,   0, "R5");
        cyc(16'h0,16, 0, 0, 0, 0, 16, 16'h0, LW0,   ADD,   16'h0, 0, "R2");
        cyc(HALT, 17, 0, 0, 0, 0, 17, HALT,  16'h0, LW0,   ADD,   0, "R6");
        cyc(16'h0,18, 0, 0, 0, 0, 18, 16'h0, HALT,  16'h0, LW0,   0, "R2");
        cyc(16'h0,19, 0, 0, 0, 0, 19, 16'h0, 16'h0, HALT,  16'h0, 0, "R2");
        cyc(16'h0,20, 0, 0, 0, 0, 20, 16'h0, 16'h0, 16'h0, HALT,  0, "R9");
        cyc(LW1,  21, 0, 0, 0, 0, 21, LW1,   16'h0, 16'h0, 16'h0, 1, "R9");
        cyc(ADD,  22, 1, 7, 0, 0, 21, LW1,   16'h0, 16'h0, 16'h0, 1, "R9");
        cyc(ADD,  23, 0, 0, 0, 0, 21, LW1,   16'h0, 16'h0, 16'h0, 1, "R9");
        @(posedge clk); #3;
        do_reset();
        cyc(LW1,   1, 0, 0, 0, 0,  1, LW1,   16'h0, 16'h0, 16'h0, 0, "R2");
        cyc(ADDC,  2, 0, 0, 0, 0,  2, ADDC,  LW1,   16'h0, 16'h0, 0, "R2");
        cyc(16'h0, 3, 0, 0, 1, 0,  2, ADDC,  16'h0, LW1,   16'h0, 0, "R3");
        cyc(16'h0, 3, 0, 0, 0, 0,  3, 16'h0, ADDC,  16'h0, LW1,   0, "R5");
        @(posedge clk); #4;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule